// File: doc/BRIEF.md
# DMA Channel Transfer Counter

This block keeps the counts for one DMA channel. Software programs three byte-wide fields through a 16-bit register port: a length byte, a low count byte and a high count byte. Each field can be written on its own through byte enables. A start pulse arms the channel and captures the transfer mode. After that, every per-unit strobe from the data mover decrements the counters. The unit reports when each block ends and when the whole transfer ends.

The mode decides how the three bytes are used. In block mode the length byte counts units within a block, and the other two bytes form a 16-bit block count. In the two other modes the three bytes form one 24-bit unit count. A field programmed to zero wraps to all ones on its first decrement, so zero gives the largest count the field can hold. Both readback words always show the live, decremented values.

Top module: `dma_count_unit`

## Requirements
- R1: After reset, both readback words are zero, the block pulse is low and the done flag is low.
- R2: A write with select 0 loads the length byte from data bits 7:0 when enable bit 0 is set. It loads the low count byte from data bits 15:8 when enable bit 1 is set. A write with select 1 and enable bit 0 loads the high count byte from data bits 7:0. The count word reads {low count byte, length byte}. The control word reads {8'h00, high count byte}.
- R3: In any mode other than 2'b10, each counted strobe decrements the 24-bit value {high, low, length} by exactly one, with borrow across bytes. The block pulse never fires in these modes.
- R4: In mode 2'b10, each counted strobe decrements the length byte. When the length byte would go from 1 to 0, it reloads instead with the value last written to it. In that cycle the 16-bit value {high, low} decrements and the block pulse is high for one cycle.
- R5: A zero field wraps to all ones on its first decrement: 24-bit zero becomes 0xFFFFFF, a zero length byte becomes 0xFF, and a zero block count becomes 0xFFFF at the end of the first block.
- R6: The done flag rises when the active counter goes from 1 to 0. In block mode this happens together with the block pulse of the final block.
- R7: While the done flag is high, strobes are not counted, the counters hold, and the flag stays high until the next start pulse.
- R8: Strobes before the first start pulse after reset are not counted.
- R9: The mode is sampled only at a start pulse. Changes on the mode input during a transfer have no effect on how counting proceeds.
- R10: A start pulse clears the done flag and the block pulse. A strobe in the same cycle as a start is not counted.
- R11: When a write and a counted strobe fall in the same cycle, the written bytes take the written value and the other bytes take their decremented value.
- R12: Counter values and both flags change on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 count word, 1 control word |
| wr_be_i | input | 2 | Byte enables for the write |
| wr_data_i | input | 16 | Write data |
| mode_i | input | 2 | Transfer mode, 2'b10 is block mode |
| start_i | input | 1 | Arms the channel and samples the mode |
| unit_i | input | 1 | One data unit moved |
| cnt_reg_o | output | 16 | Live {low count byte, length byte} |
| ctl_reg_o | output | 16 | Live {8'h00, high count byte} |
| block_done_o | output | 1 | One-cycle pulse at the end of each block |
| xfer_done_o | output | 1 | Whole transfer complete, held until the next start |

## Verification
Two events can land in the same clock cycle. One pair is a register write and a counted strobe. The bench provokes it by writing only the high byte while a strobe is counted in single mode. It then checks that the written byte wins and that the untouched bytes show the decrement. The other pair is a start and a strobe. The bench drives them together and confirms that the counters do not move and that counting begins on the next strobe.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 8;
  localparam int BLK_W  = 16;
  localparam int TOT_W  = LEN_W + BLK_W;
  localparam int NB     = TOT_W / BYTE_W;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SUCC   = 2'b01,
    MODE_BLOCK  = 2'b10,
    MODE_RSVD   = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/dma_cnt_byte.sv
module dma_cnt_byte #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  input  logic         ld_i,
  input  logic [W-1:0] nd_i,
  output logic [W-1:0] q_o
);
  // write overrides the decrement per byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wd_i;
    else if (ld_i) q_o <= nd_i;
  end
endmodule

// File: rtl/dma_cnt_step.sv
module dma_cnt_step
  import dma_cnt_pkg::*;
(
  input  logic [TOT_W-1:0] cur_i,
  input  logic [LEN_W-1:0] shadow_i,
  input  logic             blk_mode_i,
  output logic [TOT_W-1:0] nxt_o,
  output logic             blk_end_o,
  output logic             last_o
);
  logic [LEN_W-1:0] len;
  logic [BLK_W-1:0] blk;

  assign len = cur_i[LEN_W-1:0];
  assign blk = cur_i[TOT_W-1:LEN_W];

  always_comb begin
    if (blk_mode_i) begin
      blk_end_o = (len == LEN_W'(1));
      last_o    = blk_end_o && (blk == BLK_W'(1));
      nxt_o[LEN_W-1:0]     = blk_end_o ? shadow_i : len - LEN_W'(1);
      nxt_o[TOT_W-1:LEN_W] = blk_end_o ? blk - BLK_W'(1) : blk;
    end else begin
      blk_end_o = 1'b0;
      last_o    = (cur_i == TOT_W'(1));
      nxt_o     = cur_i - TOT_W'(1);
    end
  end
endmodule

// File: rtl/dma_cnt_ctrl.sv
module dma_cnt_ctrl
  import dma_cnt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       start_i,
  input  logic       unit_i,
  input  logic       blk_end_i,
  input  logic       last_i,
  output logic       fire_o,
  output logic       blk_mode_o,
  output logic       block_done_o,
  output logic       xfer_done_o
);
  logic       active_q;
  xfer_mode_e mode_q;

  // a strobe coinciding with start is dropped
  assign fire_o     = unit_i && active_q && !start_i;
  assign blk_mode_o = (mode_q == MODE_BLOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      mode_q       <= MODE_SINGLE;
      block_done_o <= 1'b0;
      xfer_done_o  <= 1'b0;
    end else begin
      block_done_o <= fire_o && blk_end_i;
      if (start_i) begin
        active_q    <= 1'b1;
        mode_q      <= xfer_mode_e'(mode_i);
        xfer_done_o <= 1'b0;
      end else if (fire_o && last_i) begin
        active_q    <= 1'b0;
        xfer_done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit
  import dma_cnt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [1:0]  wr_be_i,
  input  logic [15:0] wr_data_i,
  input  logic [1:0]  mode_i,
  input  logic        start_i,
  input  logic        unit_i,
  output logic [15:0] cnt_reg_o,
  output logic [15:0] ctl_reg_o,
  output logic        block_done_o,
  output logic        xfer_done_o
);
  logic [TOT_W-1:0] cnt_q, cnt_nxt;
  logic [LEN_W-1:0] shadow_q;
  logic [NB-1:0]    we_b;
  logic             fire, blk_mode, blk_end, last;

  // byte i lives in word i/2, lane i%2
  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign we_b[i] = wr_en_i && (wr_sel_i == 1'(i / 2)) && wr_be_i[i % 2];
    dma_cnt_byte #(.W(BYTE_W)) u_byte (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_b[i]),
      .wd_i   (wr_data_i[(i % 2) * BYTE_W +: BYTE_W]),
      .ld_i   (fire),
      .nd_i   (cnt_nxt[i * BYTE_W +: BYTE_W]),
      .q_o    (cnt_q[i * BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shadow_q <= '0;
    else if (we_b[0]) shadow_q <= wr_data_i[LEN_W-1:0];
  end

  dma_cnt_step u_step (
    .cur_i      (cnt_q),
    .shadow_i   (shadow_q),
    .blk_mode_i (blk_mode),
    .nxt_o      (cnt_nxt),
    .blk_end_o  (blk_end),
    .last_o     (last)
  );

  dma_cnt_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .start_i      (start_i),
    .unit_i       (unit_i),
    .blk_end_i    (blk_end),
    .last_i       (last),
    .fire_o       (fire),
    .blk_mode_o   (blk_mode),
    .block_done_o (block_done_o),
    .xfer_done_o  (xfer_done_o)
  );

  assign cnt_reg_o = cnt_q[15:0];
  assign ctl_reg_o = {8'h00, cnt_q[23:16]};
endmodule

// File: rtl/dma_cnt_chk.sv
module dma_cnt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        start_i,
  input logic        unit_i,
  input logic [15:0] cnt_reg_o,
  input logic [15:0] ctl_reg_o,
  input logic        block_done_o,
  input logic        xfer_done_o
);
  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o && !start_i |=> xfer_done_o);

  assert_frozen_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o && !start_i && !wr_en_i |=> $stable(cnt_reg_o) && $stable(ctl_reg_o));

  assert_start_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !xfer_done_o && !block_done_o);

  assert_block_needs_unit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |-> $past(unit_i) && !$past(start_i));

  assert_done_needs_unit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_done_o) |-> $past(unit_i) && !$past(start_i));

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unit_i && !wr_en_i |=> $stable(cnt_reg_o) && $stable(ctl_reg_o));
endmodule

bind dma_count_unit dma_cnt_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .start_i      (start_i),
  .unit_i       (unit_i),
  .cnt_reg_o    (cnt_reg_o),
  .ctl_reg_o    (ctl_reg_o),
  .block_done_o (block_done_o),
  .xfer_done_o  (xfer_done_o)
);

// File: tb/dma_count_unit_bench.sv
module dma_count_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [1:0]  wr_be_i = 2'b00;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  mode_i = 2'b00;
  logic        start_i = 1'b0, unit_i = 1'b0;
  logic [15:0] cnt_reg_o, ctl_reg_o;
  logic        block_done_o, xfer_done_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  dma_count_unit u_dma_count_unit (.*);

  function automatic logic [23:0] rd24();
    return {ctl_reg_o[7:0], cnt_reg_o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_be_i = be; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = 2'b00;
  endtask

  task automatic load24(input logic [23:0] v);
    wr(1'b0, 2'b11, v[15:0]);
    wr(1'b1, 2'b01, {8'h00, v[23:16]});
  endtask

  task automatic go(input logic [1:0] m);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = m;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic unit();
    @(negedge clk_i);
    unit_i = 1'b1;
    @(negedge clk_i);
    unit_i = 1'b0;
  endtask

  task automatic run_single(input logic [1:0] m, input int n);
    load24(24'(n));
    go(m);
    for (int k = 1; k <= n; k++) begin
      unit();
      chk("R3 count", 32'(rd24()), 32'(n - k));
      chk("R3 no block pulse", 32'(block_done_o), 0);
      chk("R6 done", 32'(xfer_done_o), 32'(k == n));
    end
    unit();
    chk("R7 ignored after done", 32'(rd24()), 0);
    chk("R7 done held", 32'(xfer_done_o), 1);
  endtask

  task automatic run_block(input int l, input int b);
    int lr;
    lr = (l == 0) ? 256 : l;
    load24({8'(b >> 8), 8'(b), 8'(l)});
    go(2'b10);
    for (int k = 1; k <= lr * b; k++) begin
      if (k == 2) mode_i = 2'b00; // R9: mode input moves mid-transfer
      unit();
      chk("R4 length", 32'(cnt_reg_o[7:0]), 32'(((k % lr) == 0) ? l : (lr - (k % lr)) & 8'hFF));
      chk("R4 block count", 32'({ctl_reg_o[7:0], cnt_reg_o[15:8]}), 32'(b - k / lr));
      chk("R4 block pulse", 32'(block_done_o), 32'((k % lr) == 0));
      chk("R6 done", 32'(xfer_done_o), 32'(k == lr * b));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    #8 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 count word", 32'(cnt_reg_o), 0);
    chk("R1 control word", 32'(ctl_reg_o), 0);
    chk("R1 flags", 32'({block_done_o, xfer_done_o}), 0);

    // R2 byte lanes
    wr(1'b0, 2'b01, 16'hAB12);
    chk("R2 length byte only", 32'(cnt_reg_o), 32'h0012);
    wr(1'b0, 2'b10, 16'h34CD);
    chk("R2 low count byte only", 32'(cnt_reg_o), 32'h3412);
    wr(1'b1, 2'b10, 16'h9900);
    chk("R2 control lane 1 ignored", 32'(ctl_reg_o), 0);
    wr(1'b1, 2'b01, 16'hEE56);
    chk("R2 high count byte", 32'(ctl_reg_o), 32'h0056);

    // R8 strobes before any start
    unit(); unit();
    chk("R8 no count before start", 32'(rd24()), 32'h563412);

    // R3 R6 R7 single and successive sweeps
    for (int n = 1; n <= 6; n++) run_single(2'b00, n);
    run_single(2'b01, 257);
    run_single(2'b11, 3);

    // R3 borrow across two bytes
    load24(24'h010000); go(2'b00); unit();
    chk("R3 borrow", 32'(rd24()), 32'h00FFFF);
    // R5 zero single
    load24(24'h000000); go(2'b01); unit();
    chk("R5 zero 24-bit wraps", 32'(rd24()), 32'hFFFFFF);
    chk("R5 not done", 32'(xfer_done_o), 0);

    // R4 R6 R9 block sweep
    for (int l = 1; l <= 4; l++)
      for (int b = 1; b <= 3; b++) run_block(l, b);
    // R5 zero length = 256 units
    run_block(0, 1);
    // R5 zero block count
    load24(24'h000001); go(2'b10); unit();
    chk("R5 zero block count wraps", 32'({ctl_reg_o[7:0], cnt_reg_o[15:8]}), 32'hFFFF);
    chk("R5 block pulse", 32'(block_done_o), 1);
    chk("R5 not done", 32'(xfer_done_o), 0);

    // R10 start with strobe in the same cycle
    load24(24'h000005);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 2'b00; unit_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; unit_i = 1'b0;
    chk("R10 strobe with start dropped", 32'(rd24()), 5);
    unit();
    chk("R10 counting after start", 32'(rd24()), 4);

    // R10 start clears done
    load24(24'h000001); go(2'b00); unit();
    chk("R6 done set", 32'(xfer_done_o), 1);
    go(2'b00);
    chk("R10 done cleared", 32'(xfer_done_o), 0);

    // R11 write and strobe together
    load24(24'h000010); go(2'b00);
    @(negedge clk_i);
    unit_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_be_i = 2'b01; wr_data_i = 16'h0005;
    @(negedge clk_i);
    unit_i = 1'b0; wr_en_i = 1'b0; wr_be_i = 2'b00;
    chk("R11 merged write and decrement", 32'(rd24()), 32'h05000F);

    // R12 no change without strobe
    @(negedge clk_i);
    chk("R12 hold when idle", 32'(rd24()), 32'h05000F);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule